// File: doc/BRIEF.md
# Two-Wire Bit-Level Target Front End

This block watches the clock and data lines of a two-wire serial bus and turns the bit activity into byte-level calls for one or more byte-oriented targets behind it. Both lines pass through a two-flop synchroniser. Start and stop conditions, bit edges and byte boundaries are then derived from the synchronised levels. The first byte after a start is split into a 7-bit target address and a direction flag. The block asks a combinational presence signal whether anything answers at that address, and it acknowledges or rejects the byte on the data line.

On the byte side, every exchange is a one-cycle strobe with its data. The response (presence, write acceptance or read data) is sampled in the same cycle. In write transfers each later byte goes out on the write strobe, and a refusal turns into a negative acknowledge. In read transfers the block fetches a byte, shifts it out most significant bit first, and watches the master's acknowledge slot to decide whether to fetch another. The data output is an open-drain drive value, where 1 means released.

States, in the order a transfer visits them:
- ST_IDLE: released.
- ST_RX: shifting in a byte.
- ST_ACK_PREP: byte accepted, waiting for the clock to fall.
- ST_ACK: driving low, waiting for the ninth rising clock.
- ST_ACK_HOLD: the receive-wait state. It keeps driving low until the clock falls.
- ST_NAK_PREP and ST_NAK: released through the ninth clock, then back to idle.
- ST_TX: driving the current read bit.
- ST_MACK: released for the master's acknowledge.
- ST_TX_LOAD: the next byte is loaded, waiting for the clock to fall.

Transitions:
- A start moves any state to ST_RX.
- A stop moves any state to ST_IDLE.
- An accepted byte in ST_RX goes to ST_ACK_PREP. A rejected byte goes to ST_NAK_PREP.
- ST_ACK_HOLD goes to ST_RX for writes and to ST_TX for reads.
- After the eighth bit, ST_TX goes to ST_MACK.
- In ST_MACK, a low acknowledge goes to ST_TX_LOAD and a high acknowledge goes to ST_IDLE.

Top module: `i2c_bit_target`

## Requirements
- R1: While reset is asserted and directly after it, sda_o is 1 (released) and no strobe (start_o, stop_o, wr_o, rd_o) is active.
- R2: A start condition is SCL high with SDA falling. SCL does not need to have been high before, so SCL rising together with SDA falling also starts a transfer.
- R3: The first byte after a start carries the target address in bits 7:1 and the direction in bit 0 (1 = read). That address appears on probe_addr_o when present_i is sampled, and on port_addr_o and port_rd_o with the resulting strobes.
- R4: If present_i is 0 for the address byte, the block releases SDA in the acknowledge slot (NAK), issues no strobe and returns to idle after the ninth rising clock. The address is marked invalid, so a following stop is not forwarded.
- R5: start_o fires only when no transfer is active. A repeated start inside an active transfer does not fire start_o again.
- R6: An accepted byte is acknowledged: sda_o is 0 during the high phase of the ninth clock and is released after that clock falls.
- R7: In a write transfer each later byte, assembled most significant bit first, is passed on wr_o with wr_data_o. If wr_ok_i is 0 in that cycle, the byte gets a NAK.
- R8: For a read address, rd_o fires in the same cycle as start_o and the byte on rd_data_i is shifted out most significant bit first. sda_o changes only while SCL is low.
- R9: A low SDA in the master's acknowledge slot fetches the next byte with rd_o. A high SDA ends the transfer with no further rd_o.
- R10: A stop condition (SCL high, SDA rising) is passed on stop_o with the current address only while a transfer to a present address is active. The transfer is then marked inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired value) |
| sda_o | output | 1 | Open-drain data drive, 1 = released |
| probe_addr_o | output | 7 | Address under query for presence |
| present_i | input | 1 | A target answers at probe_addr_o |
| start_o | output | 1 | Transfer begins (one-cycle strobe) |
| stop_o | output | 1 | Transfer ends (one-cycle strobe) |
| wr_o | output | 1 | Write a byte to the target |
| rd_o | output | 1 | Fetch a byte from the target |
| port_addr_o | output | 7 | Target address for the strobes |
| port_rd_o | output | 1 | Direction that goes with start_o |
| wr_data_o | output | 8 | Byte carried by wr_o |
| wr_ok_i | input | 1 | Target accepts the byte written |
| rd_data_i | input | 8 | Byte offered for the next rd_o |

## Verification
A line change made between clock edges is synchronised on the next two rising edges. The strobes that follow from it are valid during the cycle between the second and third edges. The state and sda_o update on the third edge. The bench drives the lines at falling clock edges and holds every bus phase for eight cycles. Acknowledge and read bits are sampled four cycles into each high phase, well after the three-edge delay. Strobes are compared at every falling edge against a queue of expected events, so each one is checked in the single cycle it is valid.

// File: rtl/i2c_bit_target_pkg.sv
package i2c_bit_target_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_PREP,
        ST_ACK,
        ST_ACK_HOLD,
        ST_NAK_PREP,
        ST_NAK,
        ST_TX,
        ST_MACK,
        ST_TX_LOAD
    } tgt_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_WRITE,
        PH_READ
    } tgt_phase_e;

endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    // One synchroniser chain per line; index 0 is the clock line, index 1 the data line.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '1;
            else        ff <= {ff[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = ff[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= lvl;
    end

    assign scl_lvl_o  = lvl[0];
    assign sda_lvl_o  = lvl[1];
    assign scl_rise_o = lvl[0] & ~prev[0];
    assign scl_fall_o = ~lvl[0] & prev[0];
    // Start needs only the present clock level to be high.
    assign start_o    = lvl[0] & prev[1] & ~lvl[1];
    assign stop_o     = lvl[0] & prev[0] & ~prev[1] & lvl[1];

endmodule

// File: rtl/i2c_tgt_rx_shift.sv
module i2c_tgt_rx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [BYTE_W-1:0] next_o,
    output logic              last_o
);
    localparam int CW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] q;
    logic [CW-1:0]     cnt;

    assign next_o = {q[BYTE_W-2:0], bit_i};
    assign last_o = (cnt == CW'(BYTE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            cnt <= '0;
        end else if (clr_i) begin
            q   <= '0;
            cnt <= '0;
        end else if (shift_i) begin
            q   <= next_o;
            cnt <= last_o ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_bit_target.sv
module i2c_bit_target
    import i2c_bit_target_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic [BYTE_W-2:0] probe_addr_o,
    input  logic              present_i,
    output logic              start_o,
    output logic              stop_o,
    output logic              wr_o,
    output logic              rd_o,
    output logic [BYTE_W-2:0] port_addr_o,
    output logic              port_rd_o,
    output logic [BYTE_W-1:0] wr_data_o,
    input  logic              wr_ok_i,
    input  logic [BYTE_W-1:0] rd_data_i
);
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CW     = $clog2(BYTE_W);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic rx_clr, rx_shift, rx_last;
    logic [BYTE_W-1:0] rx_next;

    tgt_state_e  state_q, state_n;
    tgt_phase_e  phase_q, phase_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic        rd_q, rd_n;
    logic        valid_q, valid_n;
    logic [BYTE_W-1:0] tx_q, tx_n;
    logic [CW-1:0] txc_q, txc_n;
    logic        ev_start, ev_stop, ev_wr, ev_rd, addr_phase;

    i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    i2c_tgt_rx_shift #(.BYTE_W(BYTE_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (rx_clr),
        .shift_i (rx_shift),
        .bit_i   (sda_lvl),
        .next_o  (rx_next),
        .last_o  (rx_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_ADDR;
            addr_q  <= '0;
            rd_q    <= 1'b0;
            valid_q <= 1'b0;
            tx_q    <= '1;
            txc_q   <= '0;
        end else begin
            state_q <= state_n;
            phase_q <= phase_n;
            addr_q  <= addr_n;
            rd_q    <= rd_n;
            valid_q <= valid_n;
            tx_q    <= tx_n;
            txc_q   <= txc_n;
        end
    end

    // Next-state and byte-port decisions
    always_comb begin
        state_n    = state_q;
        phase_n    = phase_q;
        addr_n     = addr_q;
        rd_n       = rd_q;
        valid_n    = valid_q;
        tx_n       = tx_q;
        txc_n      = txc_q;
        rx_clr     = 1'b0;
        rx_shift   = 1'b0;
        ev_start   = 1'b0;
        ev_stop    = 1'b0;
        ev_wr      = 1'b0;
        ev_rd      = 1'b0;
        addr_phase = 1'b0;
        if (stop_ev) begin
            state_n = ST_IDLE;
            phase_n = PH_ADDR;
            if (valid_q) begin
                ev_stop = 1'b1;
                valid_n = 1'b0;
            end
        end else if (start_ev) begin
            state_n = ST_RX;
            phase_n = PH_ADDR;
            rx_clr  = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RX: begin
                    if (scl_rise) begin
                        rx_shift = 1'b1;
                        if (rx_last) begin
                            unique case (phase_q)
                                PH_ADDR: begin
                                    addr_phase = 1'b1;
                                    if (!present_i) begin
                                        valid_n = 1'b0;
                                        state_n = ST_NAK_PREP;
                                    end else begin
                                        ev_start = !valid_q;
                                        valid_n  = 1'b1;
                                        addr_n   = rx_next[BYTE_W-1:1];
                                        rd_n     = rx_next[0];
                                        state_n  = ST_ACK_PREP;
                                        if (rx_next[0]) begin
                                            ev_rd   = 1'b1;
                                            tx_n    = rd_data_i;
                                            phase_n = PH_READ;
                                        end else begin
                                            phase_n = PH_WRITE;
                                        end
                                    end
                                end
                                PH_WRITE: begin
                                    ev_wr   = 1'b1;
                                    state_n = wr_ok_i ? ST_ACK_PREP : ST_NAK_PREP;
                                end
                                default: state_n = ST_NAK_PREP;
                            endcase
                        end
                    end
                end
                ST_ACK_PREP: if (scl_fall) state_n = ST_ACK;
                ST_ACK:      if (scl_rise) state_n = ST_ACK_HOLD;
                ST_ACK_HOLD: begin
                    if (scl_fall) begin
                        if (phase_q == PH_READ) begin
                            state_n = ST_TX;
                            txc_n   = '0;
                        end else begin
                            state_n = ST_RX;
                            rx_clr  = 1'b1;
                        end
                    end
                end
                ST_NAK_PREP: if (scl_fall) state_n = ST_NAK;
                ST_NAK: begin
                    if (scl_rise) begin
                        state_n = ST_IDLE;
                        phase_n = PH_ADDR;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (txc_q == CW'(BYTE_W - 1)) begin
                            state_n = ST_MACK;
                        end else begin
                            tx_n  = {tx_q[BYTE_W-2:0], 1'b1};
                            txc_n = txc_q + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) begin
                            state_n = ST_IDLE;
                            phase_n = PH_ADDR;
                        end else begin
                            ev_rd   = 1'b1;
                            tx_n    = rd_data_i;
                            state_n = ST_TX_LOAD;
                        end
                    end
                end
                ST_TX_LOAD: begin
                    if (scl_fall) begin
                        state_n = ST_TX;
                        txc_n   = '0;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_TX:               sda_o = tx_q[BYTE_W-1];
            ST_ACK, ST_ACK_HOLD: sda_o = 1'b0;
            default:             sda_o = 1'b1;
        endcase
        probe_addr_o = rx_next[BYTE_W-1:1];
        port_addr_o  = addr_phase ? rx_next[BYTE_W-1:1] : addr_q;
        port_rd_o    = addr_phase ? rx_next[0] : rd_q;
        wr_data_o    = rx_next;
        start_o      = ev_start;
        stop_o       = ev_stop;
        wr_o         = ev_wr;
        rd_o         = ev_rd;
    end

    // R5
    start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !valid_q);
    // R5
    start_marks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> valid_q);
    // R10
    stop_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !valid_q);
    // R7
    refuse_gives_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && !wr_ok_i) |=> (sda_o && state_q == ST_NAK_PREP));
    // R8
    sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_o) |-> !scl_lvl);
    // R8
    read_in_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |-> (valid_q || start_o));

endmodule

// File: tb/i2c_bit_target_test.sv
module i2c_bit_target_test;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_o, present_i, start_o, stop_o, wr_o, rd_o, port_rd_o, wr_ok_i;
    logic [6:0] probe_addr_o, port_addr_o;
    logic [7:0] wr_data_o, rd_data_i;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int rd_ptr = 0;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    assign sda_line = sda_m & sda_o;

    function automatic logic [7:0] rd_val(int n);
        return 8'h5A + 8'(n * 19);
    endfunction

    // Behavioural targets: present at 0x50 and 0x1A, refuse byte 0xFF
    assign present_i = (probe_addr_o == 7'h50) || (probe_addr_o == 7'h1A);
    assign wr_ok_i   = (wr_data_o != 8'hFF);
    assign rd_data_i = rd_val(rd_ptr);
    always @(posedge clk) if (rd_o) rd_ptr <= rd_ptr + 1;

    i2c_bit_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_o(sda_o),
        .probe_addr_o(probe_addr_o), .present_i(present_i), .start_o(start_o),
        .stop_o(stop_o), .wr_o(wr_o), .rd_o(rd_o), .port_addr_o(port_addr_o),
        .port_rd_o(port_rd_o), .wr_data_o(wr_data_o), .wr_ok_i(wr_ok_i),
        .rd_data_i(rd_data_i)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic take(logic [15:0] ev);
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3/R5/R7/R9/R10 port event actual %0h expected none", ev);
        end else begin
            logic [15:0] e = exp_q.pop_front();
            if (e !== ev) begin
                errors++;
                $display("FAIL R3/R5/R7/R9/R10 port event actual %0h expected %0h", ev, e);
            end
        end
    endtask

    // Event codes: 1 start {addr,dir}, 2 write data, 3 read addr, 4 stop addr
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_o) take({4'd1, 4'd0, port_addr_o, port_rd_o});
            if (wr_o)    take({4'd2, 4'd0, wr_data_o});
            if (rd_o)    take({4'd3, 4'd0, 1'b0, port_addr_o});
            if (stop_o)  take({4'd4, 4'd0, 1'b0, port_addr_o});
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        scl_m = 1'b1; sda_m = 1'b1; cyc(H);
        sda_m = 1'b0; cyc(H);
        scl_m = 1'b0; cyc(2);
    endtask

    task automatic m_rstart();
        sda_m = 1'b1; cyc(H);
        scl_m = 1'b1; cyc(H);
        sda_m = 1'b0; cyc(H);
        scl_m = 1'b0; cyc(2);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; cyc(H);
        scl_m = 1'b1; cyc(H);
        sda_m = 1'b1; cyc(H);
    endtask

    task automatic m_bit(logic b);
        sda_m = b; cyc(H);
        scl_m = 1'b1; cyc(H);
        scl_m = 1'b0; cyc(2);
    endtask

    task automatic m_write(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) m_bit(b[i]);
        sda_m = 1'b1; cyc(H);
        scl_m = 1'b1; cyc(H / 2);
        ack = sda_line; cyc(H / 2);
        scl_m = 1'b0; cyc(2);
    endtask

    task automatic m_read(logic mack, output logic [7:0] got);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            cyc(H);
            scl_m = 1'b1; cyc(H / 2);
            got[i] = sda_line; cyc(H / 2);
            scl_m = 1'b0; cyc(2);
        end
        sda_m = mack; cyc(H);
        scl_m = 1'b1; cyc(H);
        scl_m = 1'b0; cyc(2);
        sda_m = 1'b1;
    endtask

    initial begin
        logic ack;
        logic [7:0] got;
        cyc(3);
        // R1 during reset
        chk("R1 sda_o in reset", sda_o, 1);
        chk("R1 strobes in reset", {start_o, stop_o, wr_o, rd_o}, 0);
        rst_n = 1'b1;
        cyc(4);
        chk("R1 sda_o after reset", sda_o, 1);
        chk("R1 strobes after reset", {start_o, stop_o, wr_o, rd_o}, 0);

        // R3 R6 R7: write two bytes to 0x50
        exp_q.push_back({8'h10, 8'hA0});
        m_start();
        m_write(8'hA0, ack); chk("R6 address ack", ack, 0);
        exp_q.push_back({8'h20, 8'h12});
        m_write(8'h12, ack); chk("R6 data ack", ack, 0);
        exp_q.push_back({8'h20, 8'hC3});
        m_write(8'hC3, ack); chk("R7 data ack", ack, 0);
        cyc(4);
        chk("R6 released after ack", sda_o, 1);
        exp_q.push_back({8'h40, 8'h50});
        m_stop();
        chk("R10 stop forwarded", exp_q.size(), 0);

        // R4: absent address 0x33 gets NAK, no strobes, stop not forwarded
        m_start();
        m_write(8'h66, ack); chk("R4 absent nak", ack, 1);
        m_stop();
        chk("R4 no events for absent", exp_q.size(), 0);

        // R7: refused byte gets NAK; R10: stop still forwarded
        exp_q.push_back({8'h10, 8'h34});
        m_start();
        m_write(8'h34, ack); chk("R6 address ack 1A", ack, 0);
        exp_q.push_back({8'h20, 8'h5E});
        m_write(8'h5E, ack); chk("R7 accepted byte", ack, 0);
        exp_q.push_back({8'h20, 8'hFF});
        m_write(8'hFF, ack); chk("R7 refused byte nak", ack, 1);
        exp_q.push_back({8'h40, 8'h1A});
        m_stop();
        chk("R10 stop after refusal", exp_q.size(), 0);

        // R8 R9: read two bytes from 0x50
        exp_q.push_back({8'h10, 8'hA1});
        exp_q.push_back({8'h30, 8'h50});
        m_start();
        m_write(8'hA1, ack); chk("R6 read address ack", ack, 0);
        exp_q.push_back({8'h30, 8'h50});
        m_read(1'b0, got); chk("R8 first read byte", got, rd_val(0));
        m_read(1'b1, got); chk("R9 second read byte", got, rd_val(1));
        chk("R9 no read after nak", exp_q.size(), 0);
        exp_q.push_back({8'h40, 8'h50});
        m_stop();

        // R5: repeated start does not start again
        exp_q.push_back({8'h10, 8'h34});
        m_start();
        m_write(8'h34, ack); chk("R6 ack before rstart", ack, 0);
        exp_q.push_back({8'h20, 8'h07});
        m_write(8'h07, ack); chk("R7 byte before rstart", ack, 0);
        m_rstart();
        exp_q.push_back({8'h30, 8'h1A});
        m_write(8'h35, ack); chk("R5 ack after rstart", ack, 0);
        m_read(1'b1, got); chk("R5 read after rstart", got, rd_val(2));
        exp_q.push_back({8'h40, 8'h1A});
        m_stop();
        chk("R5 single start", exp_q.size(), 0);

        // R2: SCL rises while SDA falls
        scl_m = 1'b0; cyc(H);
        exp_q.push_back({8'h10, 8'hA0});
        scl_m = 1'b1; sda_m = 1'b0; cyc(H);
        scl_m = 1'b0; cyc(2);
        m_write(8'hA0, ack); chk("R2 start without prior high clock", ack, 0);
        exp_q.push_back({8'h20, 8'h99});
        m_write(8'h99, ack); chk("R2 byte after start", ack, 0);
        exp_q.push_back({8'h40, 8'h50});
        m_stop();
        cyc(4);
        chk("R10 all events seen", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule